// File: doc/BRIEF.md
# Two-Channel Converter Data Front End

This block is the digital input stage of a two-channel 10-bit converter. It takes data words from one or two parallel ports and places them in the two core code registers that drive the converter cores. Its timing follows one system clock. Per-channel write strobes and update strobes act as clock enables on that clock.

Two bus modes are available. In dual-bus mode each channel has its own port, write strobe and update strobe, and the two channels run independently. In single-bus interleaved mode every word arrives on port A. A select line steers each word into the A or the B holding latch, and the latch that is not selected keeps its value. A phase bit halves the write rate for the cores, so that each pair of accepted words loads both core registers together. An interleave reset clears the phase bit, which decides which word of a pair is first. A sleep input freezes the block and raises a power-down flag.

Top module: `dacfe_top`

## Requirements
- R1: `dual_mode` = 1 selects dual-bus operation. `dual_mode` = 0 selects interleaved operation, and in that mode `data_b`, `wr_b`, `upd_a` and `upd_b` have no effect on either output.
- R2: In dual-bus mode, a clock edge with `wr_x` high copies `data_x` into channel x's holding latch. A clock edge with `upd_x` high copies that holding latch into channel x's core register. Each channel uses only its own strobes.
- R3: In interleaved mode, a clock edge with `wr_a` high stores `data_a` in the A holding latch when `sel_a` = 1 and in the B holding latch when `sel_a` = 0.
- R4: In interleaved mode, the holding latch that is not selected on a write keeps its previous value.
- R5: In interleaved mode, a phase bit toggles on each accepted write. A write made while the phase bit is 1 completes a pair, and on the following clock edge both core registers load from both holding latches together. Only every second write produces a core load.
- R6: While `iq_rst` is high, the phase bit is held at 0 and no pair completes. The first write after release is the first word of a pair.
- R7: The latency is 4 clock edges. A dual-bus word written with both strobes held high, or the second word of an interleaved pair, appears on the output after the 4th rising edge, counting the capture edge as the first.
- R8: Codes are passed through unchanged as offset binary, with bit 9 as the MSB. Code 0 (minimum) and code 1023 (full scale) both reach the outputs intact.
- R9: While `sleep` is high, writes and updates are ignored and both outputs hold. `pwr_down` equals `sleep` delayed by one clock edge. Capture resumes with the first write after `sleep` falls.
- R10: After reset, `code_a`, `code_b` and `pwr_down` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 = dual-bus, 0 = interleaved |
| sleep | input | 1 | Power-down request |
| wr_a | input | 1 | Channel A write enable (shared write in interleaved mode) |
| wr_b | input | 1 | Channel B write enable |
| upd_a | input | 1 | Channel A core update enable (dual-bus) |
| upd_b | input | 1 | Channel B core update enable (dual-bus) |
| sel_a | input | 1 | Interleaved steering: 1 = A latch, 0 = B latch |
| iq_rst | input | 1 | Interleave phase reset |
| data_a | input | 10 | Port A data word |
| data_b | input | 10 | Port B data word |
| code_a | output | 10 | Channel A core code |
| code_b | output | 10 | Channel B core code |
| pwr_down | output | 1 | Power-down flag |

## Verification
A phase bit stuck or left uncleared by `iq_rst` makes the core load on the wrong word of a pair. This shows up within four edges of the next completed pair, as A and B codes that are swapped or stale. A fault in the recirculation of the holding latch that is not selected shows the wrong code on the other channel at its next core load. A missing freeze during sleep shows as output movement one edge after `sleep` rises. Random streams in both modes, including a phase reset in the middle of a stream, are compared every cycle against a model built from the requirements.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic {
    BUS_IQ   = 1'b0,
    BUS_DUAL = 1'b1
  } bus_mode_e;

  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
endpackage

// File: rtl/dacfe_steer.sv
module dacfe_steer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dual,
  input  logic         hold,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic         sel_a,
  input  logic [W-1:0] data_a,
  input  logic [W-1:0] data_b,
  output logic [W-1:0] lat_a,
  output logic [W-1:0] lat_b
);
  logic [W-1:0] lat_a_d, lat_b_d;
  logic         en_a, en_b;

  always_comb begin
    en_a = 1'b0;
    en_b = 1'b0;
    if (!hold) begin
      if (dual) begin
        en_a = wr_a;
        en_b = wr_b;
      end else begin
        en_a = wr_a & sel_a;
        en_b = wr_a & ~sel_a;
      end
    end
    lat_a_d = en_a ? data_a : lat_a;
    lat_b_d = en_b ? (dual ? data_b : data_a) : lat_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
    end else begin
      lat_a <= lat_a_d;
      lat_b <= lat_b_d;
    end
  end

  a_r4_b_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual && wr_a && sel_a) |=> $stable(lat_b));
  a_r4_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual && wr_a && !sel_a) |=> $stable(lat_a));
  a_r2_dual_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && !hold && wr_b) |=> (lat_b == $past(data_b)));
  a_r9_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(lat_a) && $stable(lat_b)));
endmodule

// File: rtl/dacfe_phase.sv
module dacfe_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic dual,
  input  logic hold,
  input  logic wr,
  input  logic iq_rst,
  output logic go
);
  logic ph, ph_d, go_d, ce;

  always_comb begin
    ce   = wr & ~hold & ~dual;
    go_d = ce & ph & ~iq_rst;
    if (dual || iq_rst) ph_d = 1'b0;
    else if (ce)        ph_d = ~ph;
    else                ph_d = ph;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0;
      go <= 1'b0;
    end else begin
      ph <= ph_d;
      go <= go_d;
    end
  end

  a_r6_rst_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
    iq_rst |=> !ph);
  a_r1_no_pair_in_dual: assert property (@(posedge clk) disable iff (!rst_n)
    dual |=> !go);
  a_r5_pair_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
endmodule

// File: rtl/dacfe_core.sv
module dacfe_core #(
  parameter int W    = 10,
  parameter int PIPE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dual,
  input  logic         hold,
  input  logic         go,
  input  logic [1:0]   upd,
  input  logic [W-1:0] lat  [2],
  output logic [W-1:0] code [2]
);
  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [W-1:0] core_q, core_d;
    logic [W-1:0] pipe_q [PIPE];
    logic [W-1:0] pipe_d [PIPE];
    logic         load;

    always_comb begin
      load   = ~hold & (dual ? upd[ch] : go);
      core_d = load ? lat[ch] : core_q;
      for (int s = 0; s < PIPE; s++) begin
        if (hold)        pipe_d[s] = pipe_q[s];
        else if (s == 0) pipe_d[s] = core_q;
        else             pipe_d[s] = pipe_q[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        core_q <= '0;
        for (int s = 0; s < PIPE; s++) pipe_q[s] <= '0;
      end else begin
        core_q <= core_d;
        for (int s = 0; s < PIPE; s++) pipe_q[s] <= pipe_d[s];
      end
    end

    assign code[ch] = pipe_q[PIPE-1];

    a_r9_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(code[ch]));
  end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
  parameter int W   = 10,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dual_mode,
  input  logic         sleep,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic         upd_a,
  input  logic         upd_b,
  input  logic         sel_a,
  input  logic         iq_rst,
  input  logic [W-1:0] data_a,
  input  logic [W-1:0] data_b,
  output logic [W-1:0] code_a,
  output logic [W-1:0] code_b,
  output logic         pwr_down
);
  import dacfe_pkg::*;

  // holding latch + core register account for two of the LAT edges
  localparam int PIPE = (LAT > 2) ? LAT - 2 : 1;

  logic         dual, go;
  logic [W-1:0] lat_a, lat_b;
  logic [W-1:0] lat  [NUM_CH];
  logic [W-1:0] code [NUM_CH];

  assign dual = (bus_mode_e'(dual_mode) == BUS_DUAL);

  dacfe_steer #(.W(W)) i_steer (
    .clk(clk), .rst_n(rst_n), .dual(dual), .hold(sleep),
    .wr_a(wr_a), .wr_b(wr_b), .sel_a(sel_a),
    .data_a(data_a), .data_b(data_b), .lat_a(lat_a), .lat_b(lat_b)
  );

  dacfe_phase i_phase (
    .clk(clk), .rst_n(rst_n), .dual(dual), .hold(sleep),
    .wr(wr_a), .iq_rst(iq_rst), .go(go)
  );

  assign lat[CH_A] = lat_a;
  assign lat[CH_B] = lat_b;

  dacfe_core #(.W(W), .PIPE(PIPE)) i_core (
    .clk(clk), .rst_n(rst_n), .dual(dual), .hold(sleep), .go(go),
    .upd({upd_b, upd_a}), .lat(lat), .code(code)
  );

  assign code_a = code[CH_A];
  assign code_b = code[CH_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_down <= 1'b0;
    else        pwr_down <= sleep;
  end

  a_r9_pd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> pwr_down);
  a_r9_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> !pwr_down);
endmodule

// File: tb/test_dacfe_top.sv
module test_dacfe_top;
  localparam int CLK_P = 10;
  localparam int W     = 10;

  logic clk = 1'b0;
  logic rst_n, dual_mode, sleep, wr_a, wr_b, upd_a, upd_b, sel_a, iq_rst;
  logic [W-1:0] data_a, data_b, code_a, code_b;
  logic pwr_down;

  int checks = 0, fails = 0;
  bit chk_en = 1'b0, done = 1'b0;
  string tag = "R10";

  always #(CLK_P/2) clk = ~clk;

  dacfe_top i_dacfe_top (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .sleep(sleep),
    .wr_a(wr_a), .wr_b(wr_b), .upd_a(upd_a), .upd_b(upd_b), .sel_a(sel_a),
    .iq_rst(iq_rst), .data_a(data_a), .data_b(data_b),
    .code_a(code_a), .code_b(code_b), .pwr_down(pwr_down)
  );

  // reference model written from the requirements
  logic [W-1:0] m_ia, m_ib, m_ca, m_cb, m_p1a, m_p2a, m_p1b, m_p2b;
  logic m_ph, m_go, m_pd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ia, m_ib, m_ca, m_cb, m_p1a, m_p2a, m_p1b, m_p2b} <= '0;
      {m_ph, m_go, m_pd} <= '0;
    end else begin
      m_pd <= sleep;
      if (!sleep) begin
        if (dual_mode) begin
          if (wr_a) m_ia <= data_a;
          if (wr_b) m_ib <= data_b;
          if (upd_a) m_ca <= m_ia;
          if (upd_b) m_cb <= m_ib;
        end else begin
          if (wr_a && sel_a)  m_ia <= data_a;
          if (wr_a && !sel_a) m_ib <= data_a;
          if (m_go) begin m_ca <= m_ia; m_cb <= m_ib; end
        end
        m_go <= !dual_mode && wr_a && m_ph && !iq_rst;
        m_ph <= (dual_mode || iq_rst) ? 1'b0 : (wr_a ? !m_ph : m_ph);
        m_p1a <= m_ca; m_p2a <= m_p1a;
        m_p1b <= m_cb; m_p2b <= m_p1b;
      end else begin
        m_go <= 1'b0;
        if (dual_mode || iq_rst) m_ph <= 1'b0;
      end
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      chk(tag, "code_a", code_a, m_p2a);
      chk(tag, "code_b", code_b, m_p2b);
      chk(tag, "pwr_down", pwr_down, m_pd);
    end
  end

  task automatic idle();
    {sleep, wr_a, wr_b, upd_a, upd_b, sel_a, iq_rst} = '0;
  endtask

  task automatic rand_dual(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_a = ($urandom_range(0, 3) != 0); upd_a = wr_a;
      wr_b = ($urandom_range(0, 3) != 0); upd_b = wr_b;
      data_a = W'($urandom_range(0, 1023));
      data_b = W'($urandom_range(0, 1023));
    end
  endtask

  task automatic rand_iq(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_a = ($urandom_range(0, 4) != 0);
      sel_a = $urandom_range(0, 1) != 0;
      wr_b = $urandom_range(0, 1) != 0;
      upd_a = $urandom_range(0, 1) != 0;
      upd_b = $urandom_range(0, 1) != 0;
      data_a = W'($urandom_range(0, 1023));
      data_b = W'($urandom_range(0, 1023));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; dual_mode = 1'b1; idle(); data_a = '0; data_b = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "code_a", code_a, 0);
    chk("R10", "code_b", code_b, 0);
    chk("R10", "pwr_down", pwr_down, 0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R7 R8: dual-bus latency with strobes held high, full scale then zero
    tag = "R7";
    wr_a = 1; upd_a = 1; wr_b = 1; upd_b = 1;
    repeat (5) @(negedge clk);
    data_a = 10'h3FF; data_b = 10'h000;
    @(negedge clk); data_a = 10'h000; data_b = 10'h3FF;
    @(negedge clk);
    @(negedge clk); chk("R7", "code_a early", code_a, 10'h000);
    @(negedge clk); chk("R7", "code_a at 4", code_a, 10'h3FF);
    chk("R8", "code_b zero", code_b, 10'h000);
    @(negedge clk); chk("R8", "code_a zero", code_a, 10'h000);
    chk("R8", "code_b full", code_b, 10'h3FF);

    // R2: independent dual-bus channels
    tag = "R2";
    rand_dual(400);

    // R6 R7: interleaved pairing after phase reset
    tag = "R6";
    @(negedge clk); dual_mode = 0; iq_rst = 1; wr_a = 1; sel_a = 0; data_a = 10'h111;
    repeat (2) @(negedge clk);
    iq_rst = 0; sel_a = 1; data_a = 10'h2AA; data_b = 10'h0F0;
    @(negedge clk); sel_a = 0; data_a = 10'h155;
    @(negedge clk); wr_a = 0;
    repeat (3) @(negedge clk);
    chk("R6", "pair code_a", code_a, 10'h2AA);
    chk("R7", "pair code_b", code_b, 10'h155);

    // R3 R4 R5 R1: random interleaved traffic, port B and update strobes toggling
    tag = "R3";
    rand_iq(400);
    tag = "R5";
    @(negedge clk); iq_rst = 1;
    rand_iq(3);
    @(negedge clk); iq_rst = 0;
    tag = "R1";
    rand_iq(400);

    // R9: sleep freezes outputs, then resumes
    tag = "R9";
    begin
      logic [W-1:0] ha, hb;
      @(negedge clk); sleep = 1; wr_a = 1; data_a = 10'h3C3;
      @(negedge clk);
      ha = code_a; hb = code_b;
      chk("R9", "pwr_down set", pwr_down, 1);
      repeat (8) begin
        @(negedge clk); data_a = W'($urandom_range(0, 1023)); sel_a = ~sel_a;
      end
      chk("R9", "code_a held", code_a, ha);
      chk("R9", "code_b held", code_b, hb);
      @(negedge clk); sleep = 0;
    end
    rand_iq(100);
    @(negedge clk); dual_mode = 1;
    rand_dual(100);
    @(negedge clk); sleep = 1;
    rand_dual(20);
    @(negedge clk); sleep = 0;
    rand_dual(100);

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule